// File: doc/BRIEF.md
# System Control Coprocessor Register Slice

This block is one slice of a system control coprocessor. It sits on the register-transfer path from a CPU core. Each transfer names a primary register number (CRn), a secondary number (CRm) and a 3-bit opcode_2 field. The slice implements two register numbers.

Register number 8 is a write-only command register for TLB maintenance. A write to it becomes a one-cycle command to the TLB. A read of it is trapped as undefined. Register number 13 holds two independent process identifiers, and opcode_2 picks between them:

- a fast context switch ID that keeps only the top 7 bits of the data word;
- a full-width trace ID. Every write to the trace ID is announced to an attached trace unit by a one-cycle strobe.

Decode and read data are combinational in the cycle of the transfer. Commands and strobes come from a four-state issue machine. They appear in the cycle after the write.

Issue machine states:

- `ST_IDLE`: no command.
- `ST_INV_ONE`: single-entry invalidate.
- `ST_INV_ALL`: whole-TLB invalidate.
- `ST_TRACE_NOTE`: trace ID write strobe.

Each cycle, the machine moves to the state named by the command decoded from that cycle's transfer. With no command, it moves to `ST_IDLE`. Back-to-back writes therefore give back-to-back pulses. Any state can reach any other state.

Top module: `sysctl_cop_slice`

## Requirements
- R1: During and after reset, the fast context switch ID and the trace ID read as zero. While reset is held, all command and strobe outputs are low.
- R2: A read with CRn=8 raises `xfer_undef` in the same cycle and returns zero read data. It causes no command in the next cycle.
- R3: A write with CRn=8, CRm=7, opcode_2=1 raises `tlb_inv_one` for exactly the next cycle, with `tlb_inv_addr` equal to the written data.
- R4: A write with CRn=8, CRm=7, opcode_2=0 raises `tlb_inv_all` for exactly the next cycle.
- R5: A write with CRn=13, CRm=0, opcode_2=0 stores data bits [31:25]. A read of the same selector returns them in bits [31:25], with bits [24:0] zero, in the cycle of the read strobe.
- R6: CRn=13, CRm=0, opcode_2=1 is a 32-bit read/write trace ID. A read returns the last written word.
- R7: Every trace ID write raises `trace_id_wr` for exactly the next cycle. Consecutive writes give a strobe in each following cycle.
- R8: Any other CRn/CRm/opcode_2 combination raises `xfer_undef`, leaves both IDs unchanged and issues no command.
- R9: Read transfers never raise a command or strobe. Read data is zero for writes, for undefined accesses and when no transfer is presented.
- R10: At most one of `tlb_inv_one`, `tlb_inv_all` and `trace_id_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | Transfer strobe, one transfer per cycle |
| xfer_write | input | 1 | 1 = write to coprocessor, 0 = read |
| xfer_crn | input | 4 | Primary register number |
| xfer_crm | input | 4 | Secondary register number |
| xfer_op2 | input | 3 | opcode_2 selector |
| xfer_wdata | input | 32 | Write data |
| xfer_rdata | output | 32 | Read data, same cycle as the strobe |
| xfer_undef | output | 1 | Undefined-instruction flag, same cycle |
| tlb_inv_one | output | 1 | Single-entry invalidate pulse |
| tlb_inv_all | output | 1 | Whole-TLB invalidate pulse |
| tlb_inv_addr | output | 32 | Modified virtual address for the single-entry invalidate |
| trace_id_wr | output | 1 | Trace ID write strobe |

## Verification
The bench builds the slice with its default parameters: a 32-bit word, a 7-bit context ID field and register numbers 8 and 13 with CRm 7 for TLB operations.

With these values, the following become reachable and are checked at the ports:

- the boundary between the kept field [31:25] and the dropped bits [24:0];
- all four issue-machine states, including back-to-back transitions between two command states;
- rejected encodings that sit one step from the legal ones: CRm 6, opcode_2 2 and 3, CRm 1 on register 13, and an unrelated CRn.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_INV_ONE,
        CMD_INV_ALL,
        CMD_TRACE_WR
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INV_ONE,
        ST_INV_ALL,
        ST_TRACE_NOTE
    } state_e;

endpackage

// File: rtl/cpc_decode.sv
module cpc_decode
    import cpc_pkg::*;
#(
    parameter logic [3:0] CRN_TLB   = 4'd8,
    parameter logic [3:0] CRN_PID   = 4'd13,
    parameter logic [3:0] CRM_TLB   = 4'd7,
    parameter logic [2:0] OP_ALL    = 3'd0,
    parameter logic [2:0] OP_ONE    = 3'd1,
    parameter logic [2:0] OP_FCSE   = 3'd0,
    parameter logic [2:0] OP_TRACE  = 3'd1
) (
    input  logic       valid,
    input  logic       write,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       sel_fcse,
    output logic       sel_trace,
    output cmd_e       cmd,
    output logic       undef
);

    logic pid_page;
    logic tlb_page;
    logic tlb_one;
    logic tlb_all;

    always_comb begin
        pid_page  = (crn == CRN_PID) && (crm == 4'd0);
        tlb_page  = (crn == CRN_TLB) && (crm == CRM_TLB) && write;
        sel_fcse  = valid && pid_page && (op2 == OP_FCSE);
        sel_trace = valid && pid_page && (op2 == OP_TRACE);
        tlb_one   = valid && tlb_page && (op2 == OP_ONE);
        tlb_all   = valid && tlb_page && (op2 == OP_ALL);
        undef     = valid && !(sel_fcse || sel_trace || tlb_one || tlb_all);
    end

    always_comb begin
        cmd = CMD_NONE;
        if (tlb_one)
            cmd = CMD_INV_ONE;
        else if (tlb_all)
            cmd = CMD_INV_ALL;
        else if (sel_trace && write)
            cmd = CMD_TRACE_WR;
    end

endmodule

// File: rtl/cpc_pid_regs.sv
module cpc_pid_regs #(
    parameter int DATA_W = 32,
    parameter int PID_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fcse,
    input  logic              wr_trace,
    input  logic              rd_fcse,
    input  logic              rd_trace,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int LOW_W = DATA_W - PID_W;

    logic [PID_W-1:0]  fcse_q;
    logic [DATA_W-1:0] trace_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcse_q  <= '0;
            trace_q <= '0;
        end else begin
            if (wr_fcse)
                fcse_q <= wdata[DATA_W-1:LOW_W];
            if (wr_trace)
                trace_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_fcse)
            rdata = {fcse_q, {LOW_W{1'b0}}};
        else if (rd_trace)
            rdata = trace_q;
    end

    p_fcse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fcse |=> $stable(fcse_q));
    p_trace_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_trace |=> $stable(trace_q));
    p_fcse_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fcse |=> fcse_q == $past(wdata[DATA_W-1:LOW_W]));
    p_rd_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_fcse && rd_trace));

endmodule

// File: rtl/cpc_cmd_fsm.sv
module cpc_cmd_fsm
    import cpc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd_in,
    input  logic [DATA_W-1:0] addr_in,
    output logic              inv_one,
    output logic              inv_all,
    output logic              trace_wr,
    output logic [DATA_W-1:0] inv_addr
);

    state_e            st_q;
    state_e            st_d;
    logic [DATA_W-1:0] addr_q;

    always_comb begin
        unique case (cmd_in)
            CMD_NONE:     st_d = ST_IDLE;
            CMD_INV_ONE:  st_d = ST_INV_ONE;
            CMD_INV_ALL:  st_d = ST_INV_ALL;
            CMD_TRACE_WR: st_d = ST_TRACE_NOTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
        end else begin
            st_q <= st_d;
            if (cmd_in == CMD_INV_ONE)
                addr_q <= addr_in;
        end
    end

    always_comb begin
        inv_one  = 1'b0;
        inv_all  = 1'b0;
        trace_wr = 1'b0;
        unique case (st_q)
            ST_IDLE:       ;
            ST_INV_ONE:    inv_one  = 1'b1;
            ST_INV_ALL:    inv_all  = 1'b1;
            ST_TRACE_NOTE: trace_wr = 1'b1;
        endcase
        inv_addr = addr_q;
    end

    p_one_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_one && cmd_in != CMD_INV_ONE) |=> !inv_one);
    p_all_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_in == CMD_INV_ALL) |=> inv_all);
    p_trace_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_in == CMD_TRACE_WR) |=> trace_wr);

endmodule

// File: rtl/sysctl_cop_slice.sv
module sysctl_cop_slice
    import cpc_pkg::*;
#(
    parameter int         DATA_W  = 32,
    parameter int         PID_W   = 7,
    parameter logic [3:0] CRN_TLB = 4'd8,
    parameter logic [3:0] CRN_PID = 4'd13,
    parameter logic [3:0] CRM_TLB = 4'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_valid,
    input  logic              xfer_write,
    input  logic [3:0]        xfer_crn,
    input  logic [3:0]        xfer_crm,
    input  logic [2:0]        xfer_op2,
    input  logic [DATA_W-1:0] xfer_wdata,
    output logic [DATA_W-1:0] xfer_rdata,
    output logic              xfer_undef,
    output logic              tlb_inv_one,
    output logic              tlb_inv_all,
    output logic [DATA_W-1:0] tlb_inv_addr,
    output logic              trace_id_wr
);

    logic sel_fcse;
    logic sel_trace;
    cmd_e cmd;

    cpc_decode #(
        .CRN_TLB (CRN_TLB),
        .CRN_PID (CRN_PID),
        .CRM_TLB (CRM_TLB),
        .OP_ALL  (3'd0),
        .OP_ONE  (3'd1),
        .OP_FCSE (3'd0),
        .OP_TRACE(3'd1)
    ) u_decode (
        .valid    (xfer_valid),
        .write    (xfer_write),
        .crn      (xfer_crn),
        .crm      (xfer_crm),
        .op2      (xfer_op2),
        .sel_fcse (sel_fcse),
        .sel_trace(sel_trace),
        .cmd      (cmd),
        .undef    (xfer_undef)
    );

    cpc_pid_regs #(
        .DATA_W(DATA_W),
        .PID_W (PID_W)
    ) u_pid (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fcse (sel_fcse && xfer_write),
        .wr_trace(sel_trace && xfer_write),
        .rd_fcse (sel_fcse && !xfer_write),
        .rd_trace(sel_trace && !xfer_write),
        .wdata   (xfer_wdata),
        .rdata   (xfer_rdata)
    );

    cpc_cmd_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_in  (cmd),
        .addr_in (xfer_wdata),
        .inv_one (tlb_inv_one),
        .inv_all (tlb_inv_all),
        .trace_wr(trace_id_wr),
        .inv_addr(tlb_inv_addr)
    );

    p_tlb_read_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_write && xfer_crn == CRN_TLB) |-> (xfer_undef && xfer_rdata == '0));
    p_inv_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_write && xfer_crn == CRN_TLB && xfer_crm == CRM_TLB && xfer_op2 == 3'd1)
        |=> (tlb_inv_one && tlb_inv_addr == $past(xfer_wdata)));
    p_read_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_valid || !xfer_write) |=> !(tlb_inv_one || tlb_inv_all || trace_id_wr));
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tlb_inv_one, tlb_inv_all, trace_id_wr}));
    p_undef_no_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_undef |=> !(tlb_inv_one || tlb_inv_all || trace_id_wr));

endmodule

// File: tb/test_sysctl_cop_slice.sv
module test_sysctl_cop_slice;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic        one;
        logic        all;
        logic        tr;
        logic [31:0] addr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_valid = 1'b0;
    logic        xfer_write = 1'b0;
    logic [3:0]  xfer_crn = '0;
    logic [3:0]  xfer_crm = '0;
    logic [2:0]  xfer_op2 = '0;
    logic [31:0] xfer_wdata = '0;
    logic [31:0] xfer_rdata;
    logic        xfer_undef;
    logic        tlb_inv_one;
    logic        tlb_inv_all;
    logic [31:0] tlb_inv_addr;
    logic        trace_id_wr;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];

    logic [6:0]  m_fcse  = '0;
    logic [31:0] m_trace = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_cop_slice i_sysctl_cop_slice (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_valid  (xfer_valid),
        .xfer_write  (xfer_write),
        .xfer_crn    (xfer_crn),
        .xfer_crm    (xfer_crm),
        .xfer_op2    (xfer_op2),
        .xfer_wdata  (xfer_wdata),
        .xfer_rdata  (xfer_rdata),
        .xfer_undef  (xfer_undef),
        .tlb_inv_one (tlb_inv_one),
        .tlb_inv_all (tlb_inv_all),
        .tlb_inv_addr(tlb_inv_addr),
        .trace_id_wr (trace_id_wr)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: presents one transfer per cycle, checks same-cycle outputs,
    // and queues the command expected in the following cycle.
    task automatic xfer(input logic v, input logic w, input logic [3:0] n, input logic [3:0] m,
                        input logic [2:0] o, input logic [31:0] d, input string tag);
        logic  lp;
        logic  lt;
        logic  e_undef;
        logic [31:0] e_rd;
        exp_t  e;
        @(negedge clk);
        xfer_valid = v;
        xfer_write = w;
        xfer_crn   = n;
        xfer_crm   = m;
        xfer_op2   = o;
        xfer_wdata = d;
        lp = (n == 4'd13) && (m == 4'd0) && (o == 3'd0 || o == 3'd1);
        lt = (n == 4'd8) && w && (m == 4'd7) && (o == 3'd0 || o == 3'd1);
        e_undef = v && !(lp || lt);
        e_rd = 32'h0;
        if (v && !w && lp)
            e_rd = (o == 3'd0) ? {m_fcse, 25'h0} : m_trace;
        #1;
        chk(xfer_undef === e_undef, {tag, " undef"}, {31'h0, xfer_undef}, {31'h0, e_undef});
        chk(xfer_rdata === e_rd, {tag, " rdata"}, xfer_rdata, e_rd);
        e.one  = v && w && lt && (o == 3'd1);
        e.all  = v && w && lt && (o == 3'd0);
        e.tr   = v && w && lp && (o == 3'd1);
        e.addr = d;
        sb_q.push_back(e);
        if (v && w && lp && o == 3'd0) m_fcse  = d[31:25];
        if (v && w && lp && o == 3'd1) m_trace = d;
    endtask

    task automatic idle();
        xfer(1'b0, 1'b0, 4'd0, 4'd0, 3'd0, 32'h0, "R9 idle");
    endtask

    // Monitor: compares registered command outputs after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(tlb_inv_one === e.one, "R3 inv_one pulse", {31'h0, tlb_inv_one}, {31'h0, e.one});
                chk(tlb_inv_all === e.all, "R4 inv_all pulse", {31'h0, tlb_inv_all}, {31'h0, e.all});
                chk(trace_id_wr === e.tr, "R7 trace strobe", {31'h0, trace_id_wr}, {31'h0, e.tr});
                chk($countones({tlb_inv_one, tlb_inv_all, trace_id_wr}) <= 1, "R10 exclusive",
                    {29'h0, tlb_inv_one, tlb_inv_all, trace_id_wr}, 32'h0);
                if (e.one)
                    chk(tlb_inv_addr === e.addr, "R3 inv address", tlb_inv_addr, e.addr);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: outputs quiet under reset
        repeat (3) @(negedge clk);
        chk(!(tlb_inv_one || tlb_inv_all || trace_id_wr), "R1 reset strobes",
            {29'h0, tlb_inv_one, tlb_inv_all, trace_id_wr}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: both IDs read zero after reset
        xfer(1, 0, 4'd13, 4'd0, 3'd0, 32'h0, "R1 fcse reset");
        xfer(1, 0, 4'd13, 4'd0, 3'd1, 32'h0, "R1 trace reset");

        // R5: only the top field is kept
        xfer(1, 1, 4'd13, 4'd0, 3'd0, 32'hFFFF_FFFF, "R5 fcse write ones");
        xfer(1, 0, 4'd13, 4'd0, 3'd0, 32'h0, "R5 fcse read ones");
        xfer(1, 1, 4'd13, 4'd0, 3'd0, 32'hA5A5_5A5A, "R5 fcse write pattern");
        xfer(1, 0, 4'd13, 4'd0, 3'd0, 32'h0, "R5 fcse read pattern");
        xfer(1, 1, 4'd13, 4'd0, 3'd0, 32'h01FF_FFFF, "R5 fcse low bits only");
        xfer(1, 0, 4'd13, 4'd0, 3'd0, 32'h0, "R5 fcse read low-only");

        // R6/R7: trace ID and its strobe, including back-to-back writes
        xfer(1, 1, 4'd13, 4'd0, 3'd1, 32'h1234_5678, "R7 trace write");
        xfer(1, 0, 4'd13, 4'd0, 3'd1, 32'h0, "R6 trace read");
        xfer(1, 1, 4'd13, 4'd0, 3'd1, 32'hCAFE_0001, "R7 trace b2b first");
        xfer(1, 1, 4'd13, 4'd0, 3'd1, 32'hCAFE_0002, "R7 trace b2b second");
        xfer(1, 0, 4'd13, 4'd0, 3'd1, 32'h0, "R6 trace read last");
        xfer(1, 0, 4'd13, 4'd0, 3'd0, 32'h0, "R6 fcse untouched by trace");

        // R3/R4: TLB commands, alone and back-to-back
        xfer(1, 1, 4'd8, 4'd7, 3'd1, 32'hDEAD_BEE0, "R3 inv single");
        idle();
        xfer(1, 1, 4'd8, 4'd7, 3'd0, 32'h5555_0000, "R4 inv all");
        xfer(1, 1, 4'd8, 4'd7, 3'd1, 32'h0000_1000, "R3 inv single after all");
        xfer(1, 1, 4'd8, 4'd7, 3'd0, 32'h0, "R4 inv all after single");
        xfer(1, 1, 4'd13, 4'd0, 3'd1, 32'h0BAD_F00D, "R10 trace after inv");

        // R2: reads of the TLB register trap
        xfer(1, 0, 4'd8, 4'd7, 3'd1, 32'h0, "R2 tlb read");
        xfer(1, 0, 4'd8, 4'd0, 3'd0, 32'h0, "R2 tlb read other crm");

        // R8: unimplemented encodings, then confirm nothing changed
        xfer(1, 1, 4'd13, 4'd1, 3'd0, 32'h0000_0000, "R8 pid crm nonzero");
        xfer(1, 1, 4'd13, 4'd0, 3'd2, 32'hFFFF_FFFF, "R8 pid op2 two");
        xfer(1, 1, 4'd5, 4'd0, 3'd1, 32'h1111_1111, "R8 other crn");
        xfer(1, 1, 4'd8, 4'd6, 3'd1, 32'h2222_2222, "R8 tlb crm six");
        xfer(1, 1, 4'd8, 4'd7, 3'd3, 32'h3333_3333, "R8 tlb op2 three");
        xfer(1, 0, 4'd13, 4'd1, 3'd1, 32'h0, "R8 pid read bad crm");
        xfer(1, 0, 4'd13, 4'd0, 3'd0, 32'h0, "R8 fcse unchanged");
        xfer(1, 0, 4'd13, 4'd0, 3'd1, 32'h0, "R8 trace unchanged");

        // R9: no strobe without a transfer, write returns zero read data
        xfer(0, 1, 4'd13, 4'd0, 3'd1, 32'h7777_7777, "R9 write without strobe");
        xfer(1, 0, 4'd13, 4'd0, 3'd1, 32'h0, "R9 trace still old");
        xfer(1, 1, 4'd13, 4'd0, 3'd0, 32'h8000_0000, "R9 write rdata zero");
        idle();
        idle();
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule